// File: doc/BRIEF.md
# Clock Frequency Measurement Unit

This block measures how fast an arbitrary target clock is running. It compares that clock with a known reference clock. Two counters run over one shared window. One is clocked by the reference and the other by the target clock. Software sees both counts in a single 32-bit register and computes the frequency ratio itself. With a 100 MHz reference, the target frequency in MHz is 100 × target count / reference count. The result reflects the clock that is actually running, not a configured value.

Software writes a 1 to bit 31 to begin a window. It then polls bit 30 until it reads 1 and reads both count fields in the same word. The reference counter sets the window length: the window closes when that counter reaches full scale. Start and stop requests cross into the target domain as toggles through two-flop synchronizers. The frozen target count comes back through a toggle handshake, so the word software reads never holds a half-updated count.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset, the register reads 0x00000000.
- R2: A write with bit 31 set starts a measurement. Bit 31 always reads back as 0.
- R3: Bit 30 (done) reads 0 while a window is running and becomes 1 once the target count has been handed back.
- R4: When done is 1, bits 14:0 (reference count) read 0x7FFF, the full-scale value that closes the window.
- R5: When done is 1, bits 29:15 hold the number of target-clock cycles in the window. This value is within ±4 of 32767 × f_target / f_reference.
- R6: The target count saturates at 0x7FFF and does not wrap when the target clock is faster than the reference.
- R7: Right after a start write, the register reads 0: done and both count fields are cleared.
- R8: A start written while a window is running restarts the window. The result then covers only the 32767 reference cycles that follow the restart.
- R9: A write with bit 31 clear has no effect: the register value is unchanged.
- R10: Bits 29:15 read 0 while a window is running, and stay frozen once done is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; also clocks the register port |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tgt_clk | input | 1 | Clock whose frequency is measured |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; only bit 31 has an effect |
| rd_data | output | 32 | Register read value: {0, done, target count, reference count} |

## Verification
The hardest case to reach is a restart that lands while a window is already running. A target count that was not cleared, or a reference window that was not reset, would only show up as a slightly larger final count. The bench starts a window, waits 10,000 reference cycles and starts again. It then confirms that done stays low for a full window measured from the restart. The final target count must match one window only. Separate runs set the target clock slower and faster than the reference, which reaches the saturation limit.

// File: rtl/clk_freq_meter.sv
module clk_freq_meter #(
  parameter int CNT_W = 15
) (
  input  logic        ref_clk,
  input  logic        rst_n,
  input  logic        tgt_clk,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic             start;
  logic [CNT_W-1:0] ref_cnt, tgt_q;
  logic             run, done, wait_ack, start_tgl, stop_tgl;
  logic [2:0]       ack_s;
  logic             ack_edge;

  logic [2:0]       st_s, sp_s;
  logic             st_edge, sp_edge;
  logic [CNT_W-1:0] tgt_cnt, tgt_hold;
  logic             tgt_run, ack_tgl;

  assign start    = wr_en & wr_data[31];
  assign ack_edge = ack_s[2] ^ ack_s[1];
  assign st_edge  = st_s[2] ^ st_s[1];
  assign sp_edge  = sp_s[2] ^ sp_s[1];
  assign rd_data  = 32'({done, tgt_q, ref_cnt});

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt   <= '0;
      tgt_q     <= '0;
      run       <= 1'b0;
      done      <= 1'b0;
      wait_ack  <= 1'b0;
      start_tgl <= 1'b0;
      stop_tgl  <= 1'b0;
      ack_s     <= '0;
    end else begin
      ack_s <= {ack_s[1:0], ack_tgl};
      if (start) begin
        ref_cnt   <= '0;
        tgt_q     <= '0;
        done      <= 1'b0;
        run       <= 1'b1;
        wait_ack  <= 1'b0;
        start_tgl <= ~start_tgl;
      end else begin
        if (run) begin
          if (ref_cnt == FULL) begin
            run      <= 1'b0;
            wait_ack <= 1'b1;
            stop_tgl <= ~stop_tgl;
          end else begin
            ref_cnt <= ref_cnt + 1'b1;
          end
        end
        if (wait_ack && ack_edge) begin
          tgt_q    <= tgt_hold;
          done     <= 1'b1;
          wait_ack <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge tgt_clk or negedge rst_n) begin
    if (!rst_n) begin
      st_s     <= '0;
      sp_s     <= '0;
      tgt_cnt  <= '0;
      tgt_hold <= '0;
      tgt_run  <= 1'b0;
      ack_tgl  <= 1'b0;
    end else begin
      st_s <= {st_s[1:0], start_tgl};
      sp_s <= {sp_s[1:0], stop_tgl};
      if (st_edge) begin
        tgt_cnt <= '0;
        tgt_run <= 1'b1;
      end else if (sp_edge) begin
        tgt_run  <= 1'b0;
        tgt_hold <= tgt_cnt;
        ack_tgl  <= ~ack_tgl;
      end else if (tgt_run && tgt_cnt != FULL) begin
        tgt_cnt <= tgt_cnt + 1'b1;
      end
    end
  end

  assert_start_clears_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    start |=> (rd_data == 32'd0));

  assert_done_full_window_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    done |-> (ref_cnt == FULL) && !run);

  assert_done_frozen_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(tgt_q));

  assert_running_zero_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    run |-> !done && (tgt_q == '0));

  assert_idle_write_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (wr_en && !wr_data[31] && !run && !wait_ack) |=> $stable(rd_data));

  assert_no_overflow_R6: assert property (@(posedge tgt_clk) disable iff (!rst_n)
    (tgt_cnt == FULL && !st_edge) |=> (tgt_cnt == FULL));
endmodule

// File: tb/clk_freq_meter_bench.sv
`timescale 1ns/1ps
module clk_freq_meter_bench;
  logic        ref_clk = 1'b0;
  logic        tgt_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic        wr_en   = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  real         tgt_half = 12.5;

  int checks = 0;
  int errors = 0;
  int results = 0;
  bit finished = 0;

  typedef struct { int exp; int tol; string tag; } item_t;
  item_t sb[$];

  clk_freq_meter u_clk_freq_meter (
    .ref_clk(ref_clk), .rst_n(rst_n), .tgt_clk(tgt_clk),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  always #5 ref_clk = ~ref_clk;
  initial forever #(tgt_half) tgt_clk = ~tgt_clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic write(input logic [31:0] d);
    @(negedge ref_clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge ref_clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic measure(input int exp, input int tol, input string tag);
    item_t it;
    it.exp = exp; it.tol = tol; it.tag = tag;
    sb.push_back(it);
    write(32'h8000_0000);
    check(rd_data == 32'd0, "R7", rd_data, 0);
  endtask

  task automatic wait_result(input int n);
    while (results < n) @(negedge ref_clk);
  endtask

  // monitor: pops expected items as results appear
  initial begin
    bit seen = 0;
    forever begin
      @(negedge ref_clk);
      if (rd_data[30] && !seen) begin
        item_t it;
        int tc;
        seen = 1;
        tc = int'(rd_data[29:15]);
        if (sb.size() == 0) begin
          check(0, "R3 unexpected done", rd_data, 0);
        end else begin
          it = sb.pop_front();
          check(rd_data[31] == 1'b0, "R2", rd_data, 0);
          check(rd_data[14:0] == 15'h7FFF, "R4", int'(rd_data[14:0]), 32'h7FFF);
          check(tc >= it.exp - it.tol && tc <= it.exp + it.tol, it.tag, tc, it.exp);
        end
        results++;
      end else if (!rd_data[30]) begin
        seen = 0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge ref_clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0x%08h expected 0x%08h", results, 3);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge ref_clk);
    check(rd_data == 32'd0, "R1", rd_data, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge ref_clk);
    check(rd_data == 32'd0, "R1", rd_data, 0);

    // R5: 40 MHz target -> 32767*0.4 = 13106.8
    tgt_half = 12.5;
    measure(13107, 4, "R5 slow");
    repeat (1000) @(negedge ref_clk);
    check(rd_data[30] == 1'b0, "R3", rd_data, 0);
    check(rd_data[29:15] == 15'd0, "R10", rd_data, 0);
    check(rd_data[31] == 1'b0, "R2", rd_data, 0);
    wait_result(1);
    snap = rd_data;
    // R9: bit 31 clear write is ignored
    write(32'h7FFF_FFFF);
    check(rd_data == snap, "R9", rd_data, snap);
    repeat (50) @(negedge ref_clk);
    check(rd_data == snap, "R10 frozen", rd_data, snap);

    // R6: 200 MHz target saturates
    tgt_half = 2.5;
    repeat (20) @(negedge ref_clk);
    measure(32767, 0, "R6 saturate");
    wait_result(2);

    // R8: restart mid-window, 80 MHz target -> 26213.6
    tgt_half = 6.25;
    repeat (20) @(negedge ref_clk);
    write(32'h8000_0000);
    repeat (10000) @(negedge ref_clk);
    check(rd_data[30] == 1'b0, "R3", rd_data, 0);
    measure(26214, 4, "R8 restart");
    repeat (32000) @(negedge ref_clk);
    check(rd_data[30] == 1'b0, "R8 window restarted", rd_data, 0);
    check(results == 2, "R8 no early result", results, 2);
    wait_result(3);
    check(sb.size() == 0, "R3 all results", sb.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule